// File: doc/BRIEF.md
# Run-length Huffman test decompressor

This block is the first stage of an on-chip decompressor for scan test data. The tester side presents the compressed stream one bit at a time, each bit qualified by an input strobe. The block walks a prefix-free decode tree on those bits. Because no codeword is the prefix of another, a codeword is known the moment its last bit arrives, with no look-ahead. The recognised symbol selects a run-length pattern. That pattern is a run of zeros that ends in a single one, except for the longest run, which is all zeros. The block then plays the pattern out serially at the full clock rate.

A ready output stalls the tester side while a pattern is being played out, and it rises again once the final bit has left. A completion flag marks the final bit of each pattern. A decode-enable input gates acceptance of new input bits. The codeword assignment is a synthesis parameter. A path through the tree that no table entry can complete raises an error flag, and the walker goes back to the start. One clock serves both rates: tester bits arrive on cycles with the strobe high, and expansion uses every cycle.

Top module: `rlh_decomp`

## Requirements
- R1: After synchronous reset, with dec_en high, in_ready is 1 and out_valid, cw_done and cw_err are 0.
- R2: An input bit is accepted on a rising edge where in_valid and in_ready are both high. When the accepted bit completes a codeword, out_valid is still 0 in the cycle after that edge, and the first pattern bit appears one edge later.
- R3: Symbol Lk for k = 0..3 expands to k zeros followed by a single one, so its pattern is k+1 bits. L4 expands to four zeros. Bits leave most significant first, one per clock with out_valid high.
- R4: The default codeword table is L0 = 0, L1 = 10, L2 = 110, L3 = 1110, L4 = 1111, with the first-sent bit leftmost.
- R5: in_ready is 0 from the edge that completes a codeword until the edge that shows the last pattern bit. in_valid pulses during that time are not taken and produce no output.
- R6: cw_done is high for exactly one cycle per codeword, in the same cycle as the last pattern bit, and never without out_valid.
- R7: While dec_en is 0, in_ready is 0 and input bits are not taken. The partial codeword collected so far is kept and continues once dec_en returns.
- R8: An input bit that leaves the walked path a prefix of no table entry raises cw_err for one cycle. It starts no expansion and returns the walker to the tree root.
- R9: A new codeword may begin on the first edge after in_ready returns high, so consecutive codewords expand back to back without losing or reordering bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; each cycle is one system-rate step |
| rst | input | 1 | Synchronous active-high reset |
| dec_en | input | 1 | Decode enable; gates acceptance of input bits |
| in_valid | input | 1 | Tester strobe qualifying in_bit |
| in_bit | input | 1 | Compressed stream bit |
| in_ready | output | 1 | Block can take an input bit this cycle |
| out_bit | output | 1 | Expanded pattern bit |
| out_valid | output | 1 | out_bit carries a pattern bit |
| cw_done | output | 1 | Last bit of the current pattern |
| cw_err | output | 1 | Unused tree path seen |

## Verification
The assertions rely on the codeword table being prefix-free and on no expansion starting while a previous one is still running. The second condition holds only because every accepted bit is qualified by in_ready. The stimulus therefore drives in_valid freely, including during expansion and while decoding is disabled, but it never relies on a bit being accepted unless in_ready was seen high before the edge. A second instance with an incomplete table supplies the unused paths, because the default table fills every four-bit path.

// File: rtl/rlh_pkg.sv
package rlh_pkg;

  localparam int unsigned RLH_GROUP_DEF  = 4;
  localparam int unsigned RLH_CW_MAX_DEF = 4;
  localparam int unsigned RLH_LW_DEF     = $clog2(RLH_CW_MAX_DEF + 1);

  // Entry k occupies bits [k*CW_MAX +: CW_MAX], code right-aligned, first bit leftmost.
  // Default: L0=0, L1=10, L2=110, L3=1110, L4=1111.
  localparam logic [(RLH_GROUP_DEF+1)*RLH_CW_MAX_DEF-1:0] RLH_CODE_DEF = 20'hFE620;
  // Lengths, RLH_LW_DEF bits per entry: 4,4,3,2,1 from L4 down to L0.
  localparam logic [(RLH_GROUP_DEF+1)*RLH_LW_DEF-1:0]     RLH_LEN_DEF  = 15'b100_100_011_010_001;

endpackage

// File: rtl/rlh_tree_walker.sv
module rlh_tree_walker #(
  parameter int unsigned NSYM   = 5,
  parameter int unsigned CW_MAX = 4,
  parameter int unsigned LW     = 3,
  parameter int unsigned SW     = 3,
  parameter logic [NSYM*CW_MAX-1:0] CODE_TBL = '0,
  parameter logic [NSYM*LW-1:0]     LEN_TBL  = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          bit_in,
  output logic          hit,
  output logic [SW-1:0] sym,
  output logic          err_q
);

  logic [CW_MAX-1:0] acc_q;
  logic [LW-1:0]     len_q;
  logic [CW_MAX-1:0] acc_n;
  logic [LW-1:0]     len_n;
  logic [NSYM-1:0]   full_m;
  logic [NSYM-1:0]   pre_m;

  assign acc_n = {acc_q[CW_MAX-2:0], bit_in};
  assign len_n = len_q + LW'(1);

  for (genvar k = 0; k < NSYM; k++) begin : g_entry
    logic [CW_MAX-1:0] code_k;
    logic [LW-1:0]     clen_k;
    assign code_k    = CODE_TBL[k*CW_MAX +: CW_MAX];
    assign clen_k    = LEN_TBL[k*LW +: LW];
    assign full_m[k] = (clen_k == len_n) && (code_k == acc_n);
    assign pre_m[k]  = (clen_k >= len_n) && ((code_k >> (clen_k - len_n)) == acc_n);
  end

  always_comb begin
    sym = '0;
    for (int k = NSYM - 1; k >= 0; k--) begin
      if (full_m[k]) sym = SW'(k);
    end
  end

  assign hit = accept && (|full_m);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      len_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (accept) begin
        if ((|full_m) || !(|pre_m)) begin
          acc_q <= '0;
          len_q <= '0;
          err_q <= !(|pre_m);
        end else begin
          acc_q <= acc_n;
          len_q <= len_n;
        end
      end
    end
  end

  // R2: a partial path never reaches full codeword depth without resolving
  a_r2_depth_bounded: assert property (@(posedge clk) disable iff (rst)
    len_q < LW'(CW_MAX));

  // R8: an error leaves the walker at the root
  a_r8_err_at_root: assert property (@(posedge clk) disable iff (rst)
    err_q |-> (len_q == '0));

endmodule

// File: rtl/rlh_pattern_expander.sv
module rlh_pattern_expander #(
  parameter int unsigned GROUP = 4,
  parameter int unsigned SW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [SW-1:0] sym,
  output logic          out_bit,
  output logic          out_valid,
  output logic          done,
  output logic          busy
);

  localparam int unsigned PW = GROUP + 1;
  localparam int unsigned CW = $clog2(GROUP + 2);

  logic [PW-1:0] pat_q;
  logic [CW-1:0] rem_q;
  logic          is_full_run;

  assign is_full_run = (sym == SW'(GROUP));
  assign busy        = (rem_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pat_q     <= '0;
      rem_q     <= '0;
      out_bit   <= 1'b0;
      out_valid <= 1'b0;
      done      <= 1'b0;
    end else if (load) begin
      pat_q     <= is_full_run ? '0 : (PW'(1) << (GROUP - int'(sym)));
      rem_q     <= is_full_run ? CW'(GROUP) : (CW'(sym) + CW'(1));
      out_valid <= 1'b0;
      done      <= 1'b0;
    end else if (busy) begin
      out_bit   <= pat_q[PW-1];
      out_valid <= 1'b1;
      pat_q     <= pat_q << 1;
      rem_q     <= rem_q - CW'(1);
      done      <= (rem_q == CW'(1));
    end else begin
      out_valid <= 1'b0;
      done      <= 1'b0;
    end
  end

  // R6: completion only with a valid bit
  a_r6_done_with_bit: assert property (@(posedge clk) disable iff (rst)
    done |-> out_valid);

  // R6: the serial stream ends only after its completion marker
  a_r6_end_after_done: assert property (@(posedge clk) disable iff (rst)
    $fell(out_valid) |-> $past(done));

  // R5: no new pattern while one is still playing out
  a_r5_no_load_busy: assert property (@(posedge clk) disable iff (rst)
    load |-> !busy);

endmodule

// File: rtl/rlh_decomp.sv
module rlh_decomp #(
  parameter int unsigned GROUP  = rlh_pkg::RLH_GROUP_DEF,
  parameter int unsigned CW_MAX = rlh_pkg::RLH_CW_MAX_DEF,
  parameter logic [(GROUP+1)*CW_MAX-1:0] CODE_TBL = rlh_pkg::RLH_CODE_DEF,
  parameter logic [(GROUP+1)*$clog2(CW_MAX+1)-1:0] LEN_TBL = rlh_pkg::RLH_LEN_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic dec_en,
  input  logic in_valid,
  input  logic in_bit,
  output logic in_ready,
  output logic out_bit,
  output logic out_valid,
  output logic cw_done,
  output logic cw_err
);

  localparam int unsigned NSYM = GROUP + 1;
  localparam int unsigned LW   = $clog2(CW_MAX + 1);
  localparam int unsigned SW   = $clog2(NSYM);

  logic          busy;
  logic          accept;
  logic          hit;
  logic [SW-1:0] sym;

  assign in_ready = dec_en && !busy;
  assign accept   = in_valid && in_ready;

  rlh_tree_walker #(
    .NSYM(NSYM), .CW_MAX(CW_MAX), .LW(LW), .SW(SW),
    .CODE_TBL(CODE_TBL), .LEN_TBL(LEN_TBL)
  ) u_walker (
    .clk(clk), .rst(rst), .accept(accept), .bit_in(in_bit),
    .hit(hit), .sym(sym), .err_q(cw_err)
  );

  rlh_pattern_expander #(
    .GROUP(GROUP), .SW(SW)
  ) u_expander (
    .clk(clk), .rst(rst), .load(hit), .sym(sym),
    .out_bit(out_bit), .out_valid(out_valid), .done(cw_done), .busy(busy)
  );

  // R8: an error starts no expansion
  a_r8_err_no_expand: assert property (@(posedge clk) disable iff (rst)
    cw_err |-> !busy);

  // R5: input is stalled while non-final pattern bits are leaving
  a_r5_stall_midpattern: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !cw_done) |-> !in_ready);

  // R7: no input accepted while decoding is disabled
  a_r7_gate: assert property (@(posedge clk) disable iff (rst)
    !dec_en |-> !in_ready);

endmodule

// File: tb/rlh_decomp_tb.sv
module rlh_decomp_tb;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic dec_en = 1'b0, iv = 1'b0, ib = 1'b0;
  logic rdy, ob, ov, dn, er;
  logic a_dec_en = 1'b0, a_iv = 1'b0, a_ib = 1'b0;
  logic a_rdy, a_ob, a_ov, a_dn, a_er;

  rlh_decomp u_dut (
    .clk(clk), .rst(rst), .dec_en(dec_en), .in_valid(iv), .in_bit(ib),
    .in_ready(rdy), .out_bit(ob), .out_valid(ov), .cw_done(dn), .cw_err(er)
  );

  // Incomplete table: L0=00 L1=01 L2=10 L3=110 L4=1110; path 1111 unused
  rlh_decomp #(
    .CODE_TBL(20'hE6210), .LEN_TBL(15'b100_011_010_010_010)
  ) u_dut_alt (
    .clk(clk), .rst(rst), .dec_en(a_dec_en), .in_valid(a_iv), .in_bit(a_ib),
    .in_ready(a_rdy), .out_bit(a_ob), .out_valid(a_ov), .cw_done(a_dn), .cw_err(a_er)
  );

  int n_tests = 0, n_fail = 0;
  int cap_n = 0, err_n = 0, done_n = 0, acap_n = 0, aerr_n = 0;
  logic cap_b [0:511];
  logic cap_d [0:511];
  logic acap_b [0:511];
  int exp_b [0:511];
  int exp_n = 0;
  int code_v [0:4] = '{0, 2, 6, 14, 15};
  int code_l [0:4] = '{1, 2, 3, 4, 4};

  always @(negedge clk) begin
    if (!rst) begin
      if (ov && cap_n < 512) begin cap_b[cap_n] = ob; cap_d[cap_n] = dn; cap_n++; end
      if (dn) done_n++;
      if (er) err_n++;
      if (a_ov && acap_n < 512) begin acap_b[acap_n] = a_ob; acap_n++; end
      if (a_er) aerr_n++;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_all();
    cap_n = 0; err_n = 0; done_n = 0; acap_n = 0; aerr_n = 0; exp_n = 0;
  endtask

  task automatic add_pat(input int k);
    if (k == 4) begin
      for (int j = 0; j < 4; j++) begin exp_b[exp_n] = 0; exp_n++; end
    end else begin
      for (int j = 0; j < k; j++) begin exp_b[exp_n] = 0; exp_n++; end
      exp_b[exp_n] = 1; exp_n++;
    end
  endtask

  task automatic send(input bit alt, input int bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      while (!(alt ? a_rdy : rdy)) @(negedge clk);
      if (alt) begin a_iv = 1'b1; a_ib = bits[i]; end
      else begin iv = 1'b1; ib = bits[i]; end
      @(negedge clk);
      a_iv = 1'b0; iv = 1'b0;
    end
  endtask

  task automatic settle();
    repeat (10) @(negedge clk);
  endtask

  task automatic cmp_stream(input string req, input bit alt);
    int bad = 0;
    chk(req, "bit count", alt ? acap_n : cap_n, exp_n);
    for (int i = 0; i < exp_n && i < 512; i++)
      if (int'(alt ? acap_b[i] : cap_b[i]) != exp_b[i]) bad++;
    chk(req, "mismatched bits", bad, 0);
  endtask

  task automatic t_reset();
    chk("R1", "in_ready", int'(rdy), 1);
    chk("R1", "out_valid", int'(ov), 0);
    chk("R1", "cw_done", int'(dn), 0);
    chk("R1", "cw_err", int'(er), 0);
  endtask

  task automatic t_symbols();
    for (int k = 0; k < 5; k++) begin
      int bad_done = 0;
      clear_all();
      add_pat(k);
      send(1'b0, code_v[k], code_l[k]);
      settle();
      cmp_stream("R3_R4", 1'b0);
      for (int i = 0; i < cap_n; i++)
        if (int'(cap_d[i]) != ((i == cap_n - 1) ? 1 : 0)) bad_done++;
      chk("R6", "done placement", bad_done, 0);
      chk("R6", "done pulses", done_n, 1);
    end
  endtask

  task automatic t_timing();
    clear_all();
    send(1'b0, 15, 4);
    chk("R5", "ready after final bit", int'(rdy), 0);
    chk("R2", "valid one cycle after accept", int'(ov), 0);
    @(negedge clk);
    chk("R2", "first bit two cycles after accept", int'(ov), 1);
    settle();
  endtask

  task automatic t_busy_ignore();
    clear_all();
    add_pat(2);
    send(1'b0, 6, 3);
    iv = 1'b1; ib = 1'b0;
    while (1) begin
      if (rdy) begin iv = 1'b0; break; end
      @(negedge clk);
    end
    settle();
    cmp_stream("R5", 1'b0);
  endtask

  task automatic t_dec_en();
    clear_all();
    add_pat(3);
    send(1'b0, 3, 2);
    dec_en = 1'b0;
    @(negedge clk);
    chk("R7", "ready while disabled", int'(rdy), 0);
    iv = 1'b1; ib = 1'b0;
    repeat (5) @(negedge clk);
    iv = 1'b0;
    chk("R7", "no output while disabled", cap_n, 0);
    dec_en = 1'b1;
    send(1'b0, 2, 2);
    settle();
    cmp_stream("R7", 1'b0);
  endtask

  task automatic t_back2back();
    int seq [0:5] = '{1, 0, 4, 2, 0, 3};
    clear_all();
    for (int i = 0; i < 6; i++) add_pat(seq[i]);
    for (int i = 0; i < 6; i++) send(1'b0, code_v[seq[i]], code_l[seq[i]]);
    settle();
    cmp_stream("R9", 1'b0);
    chk("R9", "completions", done_n, 6);
  endtask

  task automatic t_error();
    clear_all();
    send(1'b1, 15, 4);
    settle();
    chk("R8", "error pulses", aerr_n, 1);
    chk("R8", "no output on error", acap_n, 0);
    add_pat(0);
    add_pat(4);
    send(1'b1, 0, 2);
    send(1'b1, 14, 4);
    settle();
    cmp_stream("R8", 1'b1);
    chk("R8", "no spurious error", aerr_n, 1);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    dec_en = 1'b1;
    a_dec_en = 1'b1;
    @(negedge clk);
    t_reset();
    t_symbols();
    t_timing();
    t_busy_ignore();
    t_dec_en();
    t_back2back();
    t_error();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule